// File: doc/BRIEF.md
# PCM Voice Sample Serial Port

This block moves 14-bit linear voice samples between parallel sample buses and a frame-synchronous serial link. The link runs on an external master clock of 2.048 MHz. An 8 kHz frame-sync pulse marks each frame, so every frame is 256 clock slots long. In each frame the port shifts one transmit word out on the serial output and shifts one receive word in from the serial input. The received word is offered on a parallel bus together with a one-cycle valid strobe.

The port uses both edges of the master clock. Frame sync and serial input are sampled on the falling edge. Serial output is launched on the rising edge, so the far end can sample it half a slot later. A loopback control sends each received word back on the serial output in the following frame. Filters, converters and analog circuitry lie outside this block.

Top module: `pcm_serial_port`

## Requirements
- R1: A frame starts only when the value of `fsync_i` sampled on a falling edge is 1 and the value sampled on the previous falling edge was 0. A frame sync held high for several cycles starts exactly one frame. With no frame sync, no frame starts.
- R2: Transmit bits go out most significant bit first. Bit 13 is launched on the first rising edge after the falling edge that detected the frame start. The 14 bits then occupy 14 consecutive clock slots.
- R3: Outside those 14 slots, including while the port idles with no frame sync, `sdo_o` is 0.
- R4: `tx_sample_i` is captured on the falling edge that detects the frame start. Changes to it later in the frame have no effect on the bits sent.
- R5: The serial input is sampled on falling edges, most significant bit first. Bit 13 is taken on the first falling edge after the start edge, and bit 0 on the 14th.
- R6: On the falling edge that samples bit 0, `rx_sample_o` takes the received word and `rx_valid_o` rises. `rx_valid_o` stays high for exactly one clock. At all other times `rx_sample_o` holds its value.
- R7: `loop_en_i` is sampled at frame start. If it is 1, the frame transmits the last complete received word (the current `rx_sample_o`) instead of `tx_sample_i`. If it is 0, the frame transmits `tx_sample_i`.
- R8: While `rst_ni` is low, `sdo_o`, `rx_valid_o` and `rx_sample_o` are 0 and any frame in progress is abandoned. Because the loopback word is cleared, a loopback frame right after reset transmits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master serial clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fsync_i | input | 1 | Frame sync, sampled on falling edge |
| sdi_i | input | 1 | Serial receive data, sampled on falling edge |
| sdo_o | output | 1 | Serial transmit data, launched on rising edge |
| tx_sample_i | input | WORD_W | Transmit sample, captured at frame start |
| loop_en_i | input | 1 | 1: echo the last received word instead of the transmit sample |
| rx_sample_o | output | WORD_W | Last complete received sample |
| rx_valid_o | output | 1 | One-clock strobe when a new received sample is available |

## Verification
The in-line assertions check four things on every cycle. A detected start arms the slot counter at slot 0. The counter never passes the last bit slot. The serial output is low whenever no frame is active. The receive strobe lasts one clock and follows an active frame. They also check that a loopback frame loads the held receive word.

The bench scenarios cover what the assertions cannot. They verify the exact bit order and the slot alignment on the line, and that the input bus is ignored mid-frame. They show that a frame sync held high yields a single frame and that an idle link stays silent. They confirm that a received word is echoed in the next frame and that reset, including reset in the middle of a frame, clears the loopback word.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  function automatic int unsigned idx_w(int unsigned n);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/pcm_frame_ctrl.sv
module pcm_frame_ctrl #(
  parameter int unsigned WORD_W = 14
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fsync_i,
  output logic start_o,
  output logic busy_o,
  output logic last_o
);
  localparam int unsigned SLOT_W = pcm_port_pkg::idx_w(WORD_W);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(WORD_W - 1);

  logic              fs_prev_q;
  logic              busy_q;
  logic [SLOT_W-1:0] slot_q;

  // rising edge of the falling-edge-sampled frame sync
  assign start_o = fsync_i & ~fs_prev_q;
  assign busy_o  = busy_q;
  assign last_o  = busy_q & (slot_q == LAST_SLOT);

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_prev_q <= 1'b0;
      busy_q    <= 1'b0;
      slot_q    <= '0;
    end else begin
      fs_prev_q <= fsync_i;
      if (start_o) begin
        busy_q <= 1'b1;
        slot_q <= '0;
      end else if (busy_q) begin
        if (slot_q == LAST_SLOT) begin
          busy_q <= 1'b0;
          slot_q <= '0;
        end else begin
          slot_q <= slot_q + 1'b1;
        end
      end
    end
  end

  a_r1_start_arms: assert property (@(negedge clk_i) disable iff (!rst_ni)
    start_o |=> (busy_q && slot_q == '0));
  a_r2_slot_bound: assert property (@(negedge clk_i) disable iff (!rst_ni)
    busy_q |-> (slot_q <= LAST_SLOT));
endmodule

// File: rtl/pcm_rx_shift.sv
module pcm_rx_shift #(
  parameter int unsigned WORD_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic              last_i,
  input  logic              sdi_i,
  output logic [WORD_W-1:0] word_o,
  output logic              valid_o
);
  logic [WORD_W-1:0] sh_q;
  logic [WORD_W-1:0] sh_next;

  assign sh_next = {sh_q[WORD_W-2:0], sdi_i};

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q    <= '0;
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (busy_i) begin
        sh_q <= sh_next;
        if (last_i) begin
          word_o  <= sh_next;
          valid_o <= 1'b1;
        end
      end
    end
  end

  a_r6_valid_pulse: assert property (@(negedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);
  a_r6_valid_after_frame: assert property (@(negedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> $past(busy_i));
endmodule

// File: rtl/pcm_tx_shift.sv
module pcm_tx_shift #(
  parameter int unsigned WORD_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [WORD_W-1:0] load_word_i,
  input  logic              busy_i,
  output logic [WORD_W-1:0] sh_o,
  output logic              sdo_o
);
  logic [WORD_W-1:0] sh_q;

  assign sh_o = sh_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sh_q <= '0;
    else if (load_i) sh_q <= load_word_i;
    else if (busy_i) sh_q <= {sh_q[WORD_W-2:0], 1'b0};
  end

  // launch on rising edge, half a slot before the far end samples
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sdo_o <= 1'b0;
    else         sdo_o <= busy_i & sh_q[WORD_W-1];
  end
endmodule

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int unsigned WORD_W = 14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fsync_i,
  input  logic              sdi_i,
  output logic              sdo_o,
  input  logic [WORD_W-1:0] tx_sample_i,
  input  logic              loop_en_i,
  output logic [WORD_W-1:0] rx_sample_o,
  output logic              rx_valid_o
);
  logic              start;
  logic              busy;
  logic              last;
  logic [WORD_W-1:0] tx_sh;
  logic [WORD_W-1:0] tx_word;

  // rx_sample_o doubles as the loopback holding register
  assign tx_word = loop_en_i ? rx_sample_o : tx_sample_i;

  pcm_frame_ctrl #(.WORD_W(WORD_W)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fsync_i (fsync_i),
    .start_o (start),
    .busy_o  (busy),
    .last_o  (last)
  );

  pcm_rx_shift #(.WORD_W(WORD_W)) u_rx (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .busy_i  (busy),
    .last_i  (last),
    .sdi_i   (sdi_i),
    .word_o  (rx_sample_o),
    .valid_o (rx_valid_o)
  );

  pcm_tx_shift #(.WORD_W(WORD_W)) u_tx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .load_i      (start),
    .load_word_i (tx_word),
    .busy_i      (busy),
    .sh_o        (tx_sh),
    .sdo_o       (sdo_o)
  );

  a_r3_idle_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |=> !sdo_o);
  a_r7_loop_load: assert property (@(negedge clk_i) disable iff (!rst_ni)
    (start && loop_en_i) |=> (tx_sh == $past(rx_sample_o)));
endmodule

// File: tb/sim_pcm_serial_port.sv
module sim_pcm_serial_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fsync = 1'b0;
  logic        sdi = 1'b0;
  logic        loop_en = 1'b0;
  logic [13:0] tx_s = '0;
  logic        sdo;
  logic        rx_valid;
  logic [13:0] rx_s;
  logic [13:0] last_rx = '0;
  int          n_cmp = 0;
  int          n_bad = 0;

  always #4 clk = ~clk;

  pcm_serial_port #(.WORD_W(14)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fsync_i(fsync), .sdi_i(sdi), .sdo_o(sdo),
    .tx_sample_i(tx_s), .loop_en_i(loop_en), .rx_sample_o(rx_s), .rx_valid_o(rx_valid)
  );

  function automatic logic [13:0] exp_tx(bit lp, logic [13:0] txw, logic [13:0] held);
    return lp ? held : txw;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle_check(int n, string req);
    int bad = 0;
    fsync = 1'b0;
    repeat (n) begin
      @(negedge clk); #1;
      if (sdo !== 1'b0 || rx_valid !== 1'b0) bad++;
    end
    chk(req, bad, 0);
  endtask

  // one 256-slot frame; hold = cycles fsync stays high
  task automatic do_frame(logic [13:0] txw, logic [13:0] rxw, bit lp, int hold, string tag);
    logic [13:0] got;
    logic [13:0] want;
    int          early_v = 0;
    want = exp_tx(lp, txw, last_rx);
    @(posedge clk); #1;
    fsync = 1'b1; tx_s = txw; loop_en = lp;
    @(negedge clk);
    for (int k = 0; k < 14; k++) begin
      @(posedge clk); #1;
      fsync   = (k + 1 < hold);
      sdi     = rxw[13-k];
      tx_s    = 14'($urandom);
      loop_en = ~lp;
      @(negedge clk); #1;
      got[13-k] = sdo;
      if (k < 13 && rx_valid !== 1'b0) early_v++;
    end
    chk(tag, got, want);
    chk("R6 strobe timing", rx_valid, 1'b1);
    chk("R5 received word", rx_s, rxw);
    chk("R6 no early strobe", early_v, 0);
    @(negedge clk); #1;
    chk("R6 strobe one clock", rx_valid, 1'b0);
    chk("R6 word held", rx_s, rxw);
    chk("R3 line low after word", sdo, 1'b0);
    last_rx = rxw;
    idle_check(240, (hold > 1) ? "R1 held sync one frame" : "R3 idle slots low");
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1977));
    #3;
    chk("R8 reset sdo", sdo, 1'b0);
    chk("R8 reset valid", rx_valid, 1'b0);
    chk("R8 reset word", rx_s, 14'h0);
    #20 rst_n = 1'b1;
    idle_check(600, "R1 no sync idle");

    do_frame(14'h1234, 14'h0F0F, 1'b1, 1, "R8 loop after reset sends 0");
    do_frame(14'h2000, 14'h1555, 1'b0, 1, "R2 msb only");
    do_frame(14'h0001, 14'h2AAA, 1'b0, 1, "R2 lsb only");
    do_frame(14'h3FFF, 14'h3FFF, 1'b0, 1, "R4 all ones");
    do_frame(14'h0000, 14'h0001, 1'b1, 1, "R7 echo previous word");
    do_frame(14'h1111, 14'h2001, 1'b1, 1, "R7 echo lsb word");
    do_frame(14'h1ACE, 14'h0BEE, 1'b0, 8, "R4 held sync word");

    for (int i = 0; i < 20; i++) begin
      do_frame(14'($urandom), 14'($urandom), bit'($urandom % 2),
               1 + int'($urandom % 4), "R7 random frame");
    end

    // reset in mid-frame
    @(posedge clk); #1 fsync = 1'b1; tx_s = 14'h3FFF; loop_en = 1'b0;
    @(negedge clk);
    repeat (5) begin @(posedge clk); #1 fsync = 1'b0; sdi = 1'b1; end
    #1 rst_n = 1'b0;
    #1;
    chk("R8 mid-frame sdo", sdo, 1'b0);
    chk("R8 mid-frame word", rx_s, 14'h0);
    chk("R8 mid-frame valid", rx_valid, 1'b0);
    @(posedge clk); #1 rst_n = 1'b1;
    last_rx = '0;
    idle_check(300, "R8 abandoned frame silent");
    do_frame(14'h0555, 14'h1234, 1'b1, 1, "R8 loop word cleared");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule